// File: doc/BRIEF.md
# Two-Wire Register Bank Target

This block is the target side of a two-wire serial bus, sitting between a host controller and the control logic of a light and proximity sensing front end. It watches the clock and data lines for START, repeated START and STOP, answers only to the fixed 7-bit identifier 1000100, and gives the host byte-wide access to eleven registers. These are a constant identity byte, seven writable configuration, threshold and status registers, and three read-only result registers fed live from the conversion logic.

The host sends the identifier with R/W=0, then a register pointer, then any number of data bytes. The pointer steps by one after every data byte and wraps from the last register (0x0A) back to 0x00. To read, the host writes the pointer, issues a repeated START and sends the identifier with R/W=1. It then collects bytes for as long as it acknowledges them and ends with a NACK and a STOP. Every committed byte is also presented to the surrounding logic as a one-cycle write strobe with its address and data. The two status flags are set by the sensing logic and cleared by the host writing 0 to them. The data line is open-drain and is modelled as a pull-low enable plus the sensed line level.

Top module: `regbank_i2c_target`

## Requirements
- R1: The address byte is taken MSB first; when its upper seven bits equal 1000100 the target pulls SDA low during the ninth clock (ACK), and bit 0 selects read (1) or write (0). Any other identifier gets no ACK, and the target ignores the bus until the next START.
- R2: In a write, the target ACKs the pointer byte and each data byte, and each data byte produces exactly one one-cycle `wr_stb` pulse carrying the current pointer on `wr_addr` and the byte on `wr_data`.
- R3: After each written data byte the pointer steps by one; after 0x0A it wraps to 0x00.
- R4: A read begins at the pointer last written, returns bytes MSB first, steps the pointer after each byte with the same wrap, continues while the host ACKs and stops driving after a host NACK.
- R5: After reset the writable registers hold 0x01=0x00, 0x02=0x00, 0x03=0x00, 0x04=0xFF, 0x05=0x00, 0x06=0xF0 and 0x07=0xFF. On `cfg_flat`, register k sits at bits [8k-1:8k-8].
- R6: Register 0x00 always reads 0x2E. 0x08 reads `prox_result`, 0x09 reads `light_result[7:0]`, and 0x0A reads 0000 followed by `light_result[11:8]`. Host writes to 0x00 and 0x08 to 0x0A change nothing.
- R7: `flag_set[1]` sets bit 7 and `flag_set[0]` sets bit 3 of register 0x02. A host write clears a flag bit only where it writes 0 and leaves it unchanged where it writes 1. Bit 4 of 0x02 always reads 0, and the other bits take the written value.
- R8: A STOP before a data byte and its ACK are complete abandons the transfer: no strobe is issued and no register changes.
- R9: `sda_oe` changes only while SCL is low, and it is low whenever the target is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| prox_result | input | 8 | Proximity conversion result |
| light_result | input | 12 | Light conversion result |
| flag_set | input | 2 | Status flag set pulses: [1] proximity, [0] light |
| wr_stb | output | 1 | One-cycle strobe per committed data byte |
| wr_addr | output | 4 | Register address of the strobed byte |
| wr_data | output | 8 | Data of the strobed byte |
| cfg_flat | output | 56 | Registers 0x01 to 0x07, register k at [8k-1:8k-8] |

## Verification
The bus is driven by a bit-level host model that drives an open-drain line shared with `sda_oe`. It sends a matching and a non-matching identifier, which separates address decode from a target that always acknowledges. Burst transfers that start at 0x09 and 0x0A exercise the pointer wrap for writes and reads, which separates correct wrapping from a target that saturates or overruns into unused addresses. Flag writes of all ones and all zeros separate clear-by-zero from plain overwrite. A STOP inserted after four data bits checks that an unfinished byte leaves no trace.

// File: rtl/regbank_i2c_target.sv
module regbank_i2c_target #(
  parameter logic [6:0] DEV_ID   = 7'h44,
  parameter logic [7:0] ID_BYTE  = 8'h2E,
  parameter logic [3:0] LAST_REG = 4'hA
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  input  logic [7:0]  prox_result,
  input  logic [11:0] light_result,
  input  logic [1:0]  flag_set,
  output logic        wr_stb,
  output logic [3:0]  wr_addr,
  output logic [7:0]  wr_data,
  output logic [55:0] cfg_flat
);

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_REG, S_PACK, S_WDAT, S_WACK, S_RDAT, S_MACK
  } st_t;

  st_t        st;
  logic [2:0] scl_q, sda_q;
  logic [3:0] cnt, ptr;
  logic [7:0] sr, tx, rd_val, reg2_nxt;
  logic       rw, more;
  logic [7:0] bank [1:7];

  wire scl_s = scl_q[1];
  wire sda_s = sda_q[1];
  wire scl_rise = scl_s & ~scl_q[2];
  wire scl_fall = ~scl_s & scl_q[2];
  wire start_c  = scl_s & scl_q[2] & sda_q[2] & ~sda_s;
  wire stop_c   = scl_s & scl_q[2] & ~sda_q[2] & sda_s;
  wire [3:0] nxt = (ptr >= LAST_REG) ? 4'd0 : ptr + 4'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end

  always_comb
    case (ptr)
      4'd0:    rd_val = ID_BYTE;
      4'd1:    rd_val = bank[1];
      4'd2:    rd_val = bank[2];
      4'd3:    rd_val = bank[3];
      4'd4:    rd_val = bank[4];
      4'd5:    rd_val = bank[5];
      4'd6:    rd_val = bank[6];
      4'd7:    rd_val = bank[7];
      4'd8:    rd_val = prox_result;
      4'd9:    rd_val = light_result[7:0];
      4'd10:   rd_val = {4'h0, light_result[11:8]};
      default: rd_val = 8'h00;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; ptr <= '0; sr <= '0; tx <= '0;
      rw <= 1'b0; more <= 1'b0; sda_oe <= 1'b0;
      wr_stb <= 1'b0; wr_addr <= '0; wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (start_c) begin
        st <= S_ADDR; cnt <= '0; sda_oe <= 1'b0;
      end else if (stop_c) begin
        st <= S_IDLE; sda_oe <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_REG, S_WDAT:
            if (scl_rise) begin
              sr  <= {sr[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (st == S_ADDR) begin
                if (sr[7:1] == DEV_ID) begin
                  rw <= sr[0]; sda_oe <= 1'b1; st <= S_AACK;
                end else st <= S_IDLE;
              end else if (st == S_REG) begin
                ptr <= sr[3:0]; sda_oe <= 1'b1; st <= S_PACK;
              end else begin
                wr_stb <= 1'b1; wr_addr <= ptr; wr_data <= sr;
                ptr <= nxt; sda_oe <= 1'b1; st <= S_WACK;
              end
            end
          S_AACK, S_PACK, S_WACK:
            if (scl_fall) begin
              cnt <= '0;
              if (st == S_AACK && rw) begin
                tx <= rd_val; ptr <= nxt; sda_oe <= ~rd_val[7]; st <= S_RDAT;
              end else begin
                sda_oe <= 1'b0;
                st <= (st == S_AACK) ? S_REG : S_WDAT;
              end
            end
          S_RDAT:
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                sda_oe <= 1'b0; st <= S_MACK;
              end else begin
                tx <= {tx[6:0], 1'b0}; sda_oe <= ~tx[6]; cnt <= cnt + 4'd1;
              end
            end
          S_MACK:
            if (scl_rise) more <= ~sda_s;
            else if (scl_fall) begin
              if (more) begin
                tx <= rd_val; ptr <= nxt; sda_oe <= ~rd_val[7];
                cnt <= '0; st <= S_RDAT;
              end else st <= S_IDLE;
            end
          default: ;
        endcase
      end
    end

  always_comb begin
    reg2_nxt = bank[2];
    if (wr_stb && wr_addr == 4'd2)
      reg2_nxt = {bank[2][7] & wr_data[7], wr_data[6:5], 1'b0,
                  bank[2][3] & wr_data[3], wr_data[2:0]};
    reg2_nxt[7] = reg2_nxt[7] | flag_set[1];
    reg2_nxt[3] = reg2_nxt[3] | flag_set[0];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bank[1] <= 8'h00; bank[2] <= 8'h00; bank[3] <= 8'h00; bank[4] <= 8'hFF;
      bank[5] <= 8'h00; bank[6] <= 8'hF0; bank[7] <= 8'hFF;
    end else begin
      bank[2] <= reg2_nxt;
      for (int k = 1; k <= 7; k++)
        if (k != 2 && wr_stb && wr_addr == 4'(k)) bank[k] <= wr_data;
    end

  genvar g;
  for (g = 1; g <= 7; g++) begin : g_flat
    assign cfg_flat[8*g-1 -: 8] = bank[g];
  end

  a_r9_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe);
  a_r9_drive_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) || $fell(sda_oe)) |-> !scl_s);
  a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  a_r8_bank_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stb && flag_set == 2'b00) |=> $stable(cfg_flat));
  a_r8_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_c && !start_c) |=> (st == S_IDLE));
  a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_addr == 4'd2) |=> !cfg_flat[12]);

endmodule

// File: tb/sim_regbank_i2c_target.sv
module sim_regbank_i2c_target;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [7:0]  prox_result = 8'h5A;
  logic [11:0] light_result = 12'hABC;
  logic [1:0]  flag_set = 2'b00;
  logic sda_oe, wr_stb;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;
  logic [55:0] cfg_flat;
  wire sda_line = sda_oe ? 1'b0 : sda_m;

  int n_chk = 0, n_err = 0, n_stb = 0;
  logic [3:0] last_addr;
  logic [7:0] last_data;
  logic [7:0] rbuf [0:15];
  bit done = 0;
  localparam int Q = 10;

  always #2.5 clk = ~clk;

  regbank_i2c_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .prox_result(prox_result), .light_result(light_result), .flag_set(flag_set),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data), .cfg_flat(cfg_flat));

  always @(posedge clk)
    if (wr_stb) begin n_stb++; last_addr = wr_addr; last_data = wr_data; end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n = 1); repeat (n * Q) @(negedge clk); endtask

  task automatic bstart;
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bstop;
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(2);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); ack = (sda_line == 1'b0);
    wq(); scl_m = 1'b0; wq();
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl_m = 1'b1; wq(); b[i] = sda_line; wq(); scl_m = 1'b0; wq();
    end
    sda_m = ~give_ack; wq(); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq(); sda_m = 1'b1;
  endtask

  task automatic write_regs(input logic [3:0] a, input logic [7:0] d0, d1, d2, d3, input int n);
    logic ack;
    logic [7:0] d [0:3];
    d[0] = d0; d[1] = d1; d[2] = d2; d[3] = d3;
    bstart();
    send_byte(8'h88, ack); check("R1 write address ack", ack, 1);
    send_byte({4'h0, a}, ack); check("R2 pointer ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], ack); check("R2 data ack", ack, 1);
    end
    bstop();
  endtask

  task automatic read_regs(input logic [3:0] a, input int n);
    logic ack;
    bstart();
    send_byte(8'h88, ack);
    send_byte({4'h0, a}, ack);
    bstart();
    send_byte(8'h89, ack); check("R1 read address ack", ack, 1);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
    bstop();
    check("R4 released after nack", sda_oe, 0);
  endtask

  task automatic t_reset;
    logic [7:0] exp [0:10];
    check("R5 cfg reset", cfg_flat[31:0], 32'hFF000000);
    check("R5 cfg reset hi", cfg_flat[55:32], 24'hFFF000);
    check("R9 idle oe", sda_oe, 0);
    exp[0] = 8'h2E; exp[1] = 8'h00; exp[2] = 8'h00; exp[3] = 8'h00;
    exp[4] = 8'hFF; exp[5] = 8'h00; exp[6] = 8'hF0; exp[7] = 8'hFF;
    exp[8] = 8'h5A; exp[9] = 8'hBC; exp[10] = 8'h0A;
    read_regs(4'd0, 11);
    for (int i = 0; i < 11; i++) check("R5 R6 R4 burst read of reset map", rbuf[i], exp[i]);
  endtask

  task automatic t_addr;
    logic ack;
    bstart(); send_byte(8'h8A, ack); check("R1 wrong id no ack", ack, 0);
    check("R1 wrong id stays released", sda_oe, 0);
    send_byte(8'h03, ack); check("R1 ignored until start", ack, 0);
    bstop();
  endtask

  task automatic t_single_write;
    int s0 = n_stb;
    write_regs(4'd3, 8'h37, 0, 0, 0, 1);
    check("R2 one strobe", n_stb - s0, 1);
    check("R2 strobe addr", last_addr, 3);
    check("R2 strobe data", last_data, 8'h37);
    check("R2 reg3 value", cfg_flat[23:16], 8'h37);
    read_regs(4'd3, 1);
    check("R4 single read", rbuf[0], 8'h37);
  endtask

  task automatic t_burst_write;
    int s0 = n_stb;
    write_regs(4'd9, 8'h11, 8'h22, 8'h33, 8'h44, 4);
    check("R2 strobes per byte", n_stb - s0, 4);
    check("R3 wrap reaches reg1 last", last_addr, 1);
    check("R3 reg1 written", cfg_flat[7:0], 8'h44);
    read_regs(4'd8, 3);
    check("R6 reg8 read-only", rbuf[0], 8'h5A);
    check("R6 reg9 read-only", rbuf[1], 8'hBC);
    check("R6 reg10 read-only", rbuf[2], 8'h0A);
  endtask

  task automatic t_read_wrap;
    read_regs(4'd10, 3);
    check("R4 wrap read 0x0A", rbuf[0], 8'h0A);
    check("R4 wrap read 0x00", rbuf[1], 8'h2E);
    check("R4 wrap read 0x01", rbuf[2], 8'h44);
  endtask

  task automatic t_flags;
    @(negedge clk); flag_set = 2'b11; @(negedge clk); flag_set = 2'b00;
    check("R7 flags set", cfg_flat[15:8], 8'h88);
    write_regs(4'd2, 8'hFF, 0, 0, 0, 1);
    check("R7 write ones keeps flags, bit4 zero", cfg_flat[15:8], 8'hEF);
    write_regs(4'd2, 8'h00, 0, 0, 0, 1);
    check("R7 write zero clears", cfg_flat[15:8], 8'h00);
    @(negedge clk); flag_set = 2'b01; @(negedge clk); flag_set = 2'b00;
    read_regs(4'd2, 1);
    check("R7 light flag read", rbuf[0], 8'h08);
  endtask

  task automatic t_stop_mid;
    logic ack;
    int s0 = n_stb;
    bstart(); send_byte(8'h88, ack); send_byte(8'h05, ack);
    send_bits(8'hA5, 4);
    bstop();
    check("R8 no strobe", n_stb - s0, 0);
    check("R8 reg5 unchanged", cfg_flat[39:32], 8'h00);
    check("R9 released after stop", sda_oe, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk); rst_n = 1'b1; repeat (5) @(negedge clk);
    t_reset(); t_addr(); t_single_write(); t_burst_write();
    t_read_wrap(); t_flags(); t_stop_mid();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1; n_chk++; n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule